// File: doc/BRIEF.md
# Serial ADC Capture Controller

This block runs an external 8-bit successive-approximation converter that returns its result over a serial line, and hands each result to the rest of the chip as a parallel byte. A conversion begins either on a one-cycle request from the core or on each tick of a built-in sample timer. The block raises the convert line, which starts the converter's sample on its rising edge, and holds it high for a fixed wait that covers the converter's conversion time of about 4 µs. It then generates eight serial clock cycles and shifts in the data, most significant bit first. When the last bit has been taken, it loads the result register and pulses a valid strobe for one cycle.

With the default parameters at a 50 MHz system clock, the conversion wait is 200 clocks and the sample timer period is 270 clocks (5.4 µs, about 185 kilosamples per second). The serial clock is the system clock divided by twice a half-period parameter. The code is plain unsigned binary, one step per VREF/256, so the byte needs no conversion. Requests that arrive while a conversion is running are dropped and are not queued.

Top module: `adc_serial_capture`

## Requirements
- R1: While reset is held and until the first conversion, `conv_o`, `sclk_o` and `result_vld_o` are low and `result_o` is 0.
- R2: A high `start_req` sampled in the idle state drives `conv_o` high on the next clock edge.
- R3: `conv_o` stays high for exactly `CONV_CYCLES` system clocks per conversion, and `sclk_o` is low for that whole time.
- R4: After the wait, `sclk_o` makes exactly 8 rising edges. Each high phase and each low phase lasts `SCLK_HALF` clocks, and `sclk_o` idles low outside the readout.
- R5: `sdata_i` is sampled at each rising edge of `sclk_o`. The first bit taken lands in `result_o[7]` and the last in `result_o[0]`, so the byte is the converter's straight binary code.
- R6: `result_o` changes only on the clock edge where the 8th serial clock falls. `result_vld_o` is high for exactly that one cycle, and `result_o` then holds until the next completed conversion.
- R7: A `start_req` pulse or a timer tick that occurs while a conversion is in progress is ignored: it causes no second convert pulse and no second result.
- R8: While `auto_en` is high, conversions start every `TIMER_PERIOD` clocks. Once `auto_en` is low, no further conversions start unless `start_req` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_req | input | 1 | One-shot conversion request |
| auto_en | input | 1 | Enables the free-running sample timer |
| conv_o | output | 1 | Convert line to the converter; rising edge starts a sample |
| sclk_o | output | 1 | Serial clock to the converter, idles low |
| sdata_i | input | 1 | Serial data from the converter |
| result_o | output | 8 | Last completed conversion result |
| result_vld_o | output | 1 | One-cycle strobe marking a new result |

## Verification
On every cycle the assertions check that the convert line and serial clock are never high together, that the serial clock is low outside the readout, that the convert pulse ends only after the full wait count, that the bit counter never passes eight, that the valid strobe lasts one cycle and arrives only at the end of a readout, and that the result holds between strobes. Only the bench scenarios can show that the captured byte equals the bits the converter model sent, in MSB-first order, that the exact pulse and phase lengths are right, that requests during a conversion leave no trace, and that timer-started conversions come at the programmed spacing and stop when the timer is disabled.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  localparam int unsigned ADC_BITS = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2
  } cap_state_e;
endpackage

// File: rtl/adc_cap_timer.sv
module adc_cap_timer #(
  parameter int unsigned PERIOD = 270
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == LAST);
  assign tick = en && wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (!en)       cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8: the timer count never goes past its period
  p_timer_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/adc_cap_sclk.sv
module adc_cap_sclk #(
  parameter int unsigned SCLK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise,
  output logic fall
);
  localparam int unsigned CW = $clog2(SCLK_HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(SCLK_HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;
  logic          edge_now;

  assign edge_now = run && (cnt_q == LAST);
  assign rise     = edge_now && !sclk_q;
  assign fall     = edge_now && sclk_q;
  assign sclk     = sclk_q;

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (edge_now) begin
      cnt_d  = '0;
      sclk_d = !sclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  // R4: serial clock is low in any cycle after the readout was not running
  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk_q);
endmodule

// File: rtl/adc_cap_shift.sv
module adc_cap_shift #(
  parameter int unsigned BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            sample,
  input  logic            sdata,
  input  logic            commit,
  output logic            full,
  output logic [BITS-1:0] result,
  output logic            result_vld
);
  localparam int unsigned NW = $clog2(BITS + 1);
  localparam logic [NW-1:0] NFULL = NW'(BITS);

  logic [BITS-1:0] sr_q, sr_d;
  logic [NW-1:0]   n_q, n_d;
  logic [BITS-1:0] res_q, res_d;
  logic            vld_q, vld_d;
  logic            take;

  assign full = (n_q == NFULL);
  assign take = sample && !full;

  always_comb begin
    sr_d  = sr_q;
    n_d   = n_q;
    res_d = res_q;
    vld_d = 1'b0;
    if (clear) begin
      n_d = '0;
    end else if (take) begin
      sr_d = {sr_q[BITS-2:0], sdata};
      n_d  = n_q + 1'b1;
    end
    if (commit && full) begin
      res_d = sr_q;
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      n_q   <= '0;
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (clear || take) begin
        sr_q <= sr_d;
        n_q  <= n_d;
      end
      if (commit && full) res_q <= res_d;
      vld_q <= vld_d;
    end
  end

  assign result     = res_q;
  assign result_vld = vld_q;

  // R5: no more than BITS bits are ever taken in one readout
  p_bit_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    n_q <= NFULL);
  // R6: the strobe lasts a single cycle
  p_vld_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
  // R6: the result holds unless a new strobe comes with it
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> $stable(res_q));
endmodule

// File: rtl/adc_serial_capture.sv
module adc_serial_capture #(
  parameter int unsigned CONV_CYCLES  = 200,
  parameter int unsigned SCLK_HALF    = 2,
  parameter int unsigned TIMER_PERIOD = 270
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_req,
  input  logic       auto_en,
  output logic       conv_o,
  output logic       sclk_o,
  input  logic       sdata_i,
  output logic [7:0] result_o,
  output logic       result_vld_o
);
  import adc_cap_pkg::*;

  localparam int unsigned WW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [WW-1:0] WAIT_LAST = WW'(CONV_CYCLES - 1);

  // asynchronous assert, synchronous release
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic rst_int_n;
  assign rst_int_n = rst_s2_q;

  cap_state_e    state_q, state_d;
  logic [WW-1:0] wait_q, wait_d;
  logic          tick, trig;
  logic          sc_rise, sc_fall, sc_clk;
  logic          full;
  logic          in_conv, in_shift;

  adc_cap_timer #(.PERIOD(TIMER_PERIOD)) u_timer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (auto_en),
    .tick  (tick)
  );

  assign trig     = start_req || tick;
  assign in_conv  = (state_q == ST_CONV);
  assign in_shift = (state_q == ST_SHIFT);

  always_comb begin
    state_d = state_q;
    wait_d  = '0;
    unique case (state_q)
      ST_IDLE:  if (trig) state_d = ST_CONV;
      ST_CONV: begin
        if (wait_q == WAIT_LAST) state_d = ST_SHIFT;
        else                     wait_d  = wait_q + 1'b1;
      end
      ST_SHIFT: if (sc_fall && full) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
    end
  end

  adc_cap_sclk #(.SCLK_HALF(SCLK_HALF)) u_sclk (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run   (in_shift),
    .sclk  (sc_clk),
    .rise  (sc_rise),
    .fall  (sc_fall)
  );

  adc_cap_shift #(.BITS(ADC_BITS)) u_shift (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clear      (in_conv),
    .sample     (sc_rise && in_shift),
    .sdata      (sdata_i),
    .commit     (sc_fall && in_shift),
    .full       (full),
    .result     (result_o),
    .result_vld (result_vld_o)
  );

  assign conv_o = in_conv;
  assign sclk_o = sc_clk;

  // R3: the convert pulse ends only once the whole wait has been counted
  p_conv_len_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(conv_o) |-> $past(wait_q) == WAIT_LAST);
  // R3: convert line and serial clock are never high together
  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(conv_o && sclk_o));
  // R7: a new convert pulse is only started from the idle state
  p_start_idle_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(conv_o) |-> $past(state_q) == ST_IDLE);
  // R6: a strobe follows only a readout with all bits taken
  p_vld_after_shift_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    result_vld_o |-> ($past(state_q) == ST_SHIFT) && !in_shift);
endmodule

// File: tb/test_adc_serial_capture.sv
module test_adc_serial_capture;
  localparam int unsigned CONV_CYCLES  = 200;
  localparam int unsigned SCLK_HALF    = 2;
  localparam int unsigned TIMER_PERIOD = 270;

  logic       clk;
  logic       rst_n;
  logic       start_req;
  logic       auto_en;
  logic       conv_o;
  logic       sclk_o;
  logic       sdata_i;
  logic [7:0] result_o;
  logic       result_vld_o;

  int unsigned n_chk;
  int unsigned n_bad;
  int unsigned cyc;
  bit          done;

  logic [7:0] adc_byte;
  logic [7:0] adc_sr;

  adc_serial_capture #(
    .CONV_CYCLES  (CONV_CYCLES),
    .SCLK_HALF    (SCLK_HALF),
    .TIMER_PERIOD (TIMER_PERIOD)
  ) i_adc_serial_capture (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_req    (start_req),
    .auto_en      (auto_en),
    .conv_o       (conv_o),
    .sclk_o       (sclk_o),
    .sdata_i      (sdata_i),
    .result_o     (result_o),
    .result_vld_o (result_vld_o)
  );

  initial clk = 1'b0;
  always #10 clk = !clk;

  // converter model: MSB ready when the wait ends, next bit after each fall
  initial begin
    adc_sr  = '0;
    sdata_i = 1'b0;
  end
  always @(negedge conv_o) begin
    adc_sr  = adc_byte;
    sdata_i = adc_sr[7];
  end
  always @(negedge sclk_o) begin
    adc_sr  = {adc_sr[6:0], 1'b0};
    sdata_i = adc_sr[7];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=%0d cycles expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n     = 1'b0;
    start_req = 1'b0;
    auto_en   = 1'b0;
    adc_byte  = 8'h00;
    repeat (3) @(negedge clk);
    chk(conv_o == 1'b0, "R1 conv low in reset", conv_o, 0);
    chk(sclk_o == 1'b0, "R1 sclk low in reset", sclk_o, 0);
    chk(result_vld_o == 1'b0, "R1 valid low in reset", result_vld_o, 0);
    chk(result_o == 8'h00, "R1 result zero in reset", result_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(conv_o == 1'b0 && result_vld_o == 1'b0, "R1 idle after release",
        {conv_o, result_vld_o}, 0);
  endtask

  // one request-started conversion; optional extra requests while busy
  task automatic t_conv(input logic [7:0] b, input bit poke);
    int unsigned conv_hi;
    int unsigned extra;
    int unsigned rises;
    int unsigned hlen;
    int unsigned llen;
    int unsigned it;
    bit          pconv;
    bit          psclk;
    bit          phase_bad;
    bit          got;
    adc_byte = b;
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    chk(conv_o == 1'b1, "R2 conv rises after request", conv_o, 1);
    conv_hi = 1; extra = 0; rises = 0; hlen = 0; llen = 0;
    pconv = 1'b1; psclk = 1'b0; phase_bad = 1'b0; got = 1'b0;
    for (it = 0; it < 2000 && !got; it++) begin
      @(negedge clk);
      start_req = poke && (it == 10 || it == 220);
      if (conv_o) conv_hi++;
      if (conv_o && !pconv) extra++;
      if (conv_o && sclk_o) phase_bad = 1'b1;
      if (sclk_o && !psclk) begin
        if (rises > 0 && llen != SCLK_HALF) phase_bad = 1'b1;
        rises++; hlen = 1;
      end else if (sclk_o) hlen++;
      else if (!sclk_o && psclk) begin
        if (hlen != SCLK_HALF) phase_bad = 1'b1;
        llen = 1;
      end else if (rises > 0) llen++;
      if (result_vld_o) got = 1'b1;
      pconv = conv_o; psclk = sclk_o;
    end
    start_req = 1'b0;
    chk(got, "R6 valid strobe seen", got, 1);
    chk(conv_hi == CONV_CYCLES, "R3 conv pulse length", conv_hi, CONV_CYCLES);
    chk(!phase_bad, "R4 sclk phases and no overlap with conv", phase_bad, 0);
    chk(rises == 8, "R4 sclk rising edge count", rises, 8);
    chk(sclk_o == 1'b0, "R4 sclk low at end", sclk_o, 0);
    chk(result_o == b, "R5 captured byte MSB first", result_o, b);
    chk(extra == 0, "R7 no second convert during busy", extra, 0);
    @(negedge clk);
    chk(result_vld_o == 1'b0, "R6 valid is one cycle", result_vld_o, 1'b0);
    extra = 0; got = 1'b0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (conv_o) extra++;
      if (result_vld_o) got = 1'b1;
      if (result_o != b) phase_bad = 1'b1;
    end
    chk(extra == 0 && !got, "R7 ignored request not queued", extra + got, 0);
    chk(!phase_bad && result_o == b, "R6 result holds after strobe", result_o, b);
  endtask

  task automatic t_timer(input logic [7:0] b);
    int unsigned t_rise [3];
    int unsigned nr;
    int unsigned nv;
    int unsigned it;
    bit          pconv;
    bit          bad;
    adc_byte = b;
    nr = 0; nv = 0; pconv = 1'b0; bad = 1'b0;
    @(negedge clk) auto_en = 1'b1;
    for (it = 0; it < 5 * TIMER_PERIOD && nv < 3; it++) begin
      @(negedge clk);
      if (conv_o && !pconv && nr < 3) begin
        t_rise[nr] = it; nr++;
      end
      if (result_vld_o) begin
        nv++;
        if (result_o != b) bad = 1'b1;
      end
      pconv = conv_o;
    end
    auto_en = 1'b0;
    chk(nr == 3, "R8 three timer conversions", nr, 3);
    chk(nv == 3 && !bad, "R8 timer results correct", result_o, b);
    if (nr == 3) begin
      chk(t_rise[1] - t_rise[0] == TIMER_PERIOD, "R8 timer spacing 1",
          t_rise[1] - t_rise[0], TIMER_PERIOD);
      chk(t_rise[2] - t_rise[1] == TIMER_PERIOD, "R8 timer spacing 2",
          t_rise[2] - t_rise[1], TIMER_PERIOD);
    end
    nr = 0;
    for (int k = 0; k < 2 * TIMER_PERIOD; k++) begin
      @(negedge clk);
      if (conv_o && !pconv) nr++;
      pconv = conv_o;
    end
    chk(nr == 0, "R8 no conversions with timer off", nr, 0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; cyc = 0; done = 1'b0;
    t_reset();
    t_conv(8'hA5, 1'b0);
    t_conv(8'h00, 1'b0);
    t_conv(8'hFF, 1'b0);
    t_conv(8'h01, 1'b0);
    t_conv(8'h80, 1'b1);
    t_conv(8'h5A, 1'b1);
    t_timer(8'h3C);
    t_conv(8'hC3, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule